// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is a serial peripheral slave through which an external controller reads and writes a bank of 64 byte-wide registers. The controller pulls the active-low select low and clocks bytes in SPI mode 0. Bits are sampled on the rising serial clock edge and shifted most significant bit first. The first byte of every transaction is a command byte. Every byte after it is a data byte, and a burst may run for as many data bytes as the controller likes. Raising the select ends the transaction at once, even in the middle of a burst or a byte.

The command byte carries three fields:
- Bit 7 is the direction: 1 means write and 0 means read.
- Bit 6 is the auto-increment flag.
- Bits 5..0 hold the starting register address.

With increment set, the address steps by one after each data byte and wraps from 63 to 0. With increment clear, every byte of the burst uses the same register.

A static configuration input selects the wiring:
- In 4-wire mode, data enters on a dedicated input line and leaves on a dedicated output line.
- In 3-wire mode, a single shared bidirectional line is used. It is presented here as separate in, out and output-enable signals. The slave drives the line only while it returns read data.

All serial inputs are brought into the system clock domain through synchronizers. Each completed write byte also produces a one-cycle strobe, which carries its address and data.

Top module: `spireg_slave`

## Requirements
- R1: After reset, no write strobe is issued, both output enables are low, and every register reads back as 0x00.
- R2: In the command byte, bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 5..0 give the starting register address.
- R3: Each complete data byte of a write transaction is stored in the addressed register. It also raises wr_stb for exactly one clock, with wr_addr and wr_data equal to that address and byte.
- R4: With command bit 6 = 1, the address advances by one after each data byte, for both reads and writes, and wraps from 63 to 0.
- R5: With command bit 6 = 0, every data byte of the burst accesses the starting address.
- R6: In a read, the addressed register is returned MSB first during the byte period that follows the command byte. Each bit is valid before the rising edge on which the controller samples it, and it changes only after a falling edge.
- R7: Raising select ends the transaction. A partial byte is discarded, and the first byte after select is lowered again is treated as a command byte.
- R8: In 4-wire mode (cfg_3wire = 0), data is taken from spi_mosi. spi_miso_oe is high exactly while spi_csn is low, and spi_sdat_oe stays low.
- R9: In 3-wire mode (cfg_3wire = 1), data is taken from spi_sdat_i and spi_miso_oe stays low. spi_sdat_oe is high only during the data bytes of a read transaction while selected.
- R10: The input bits clocked during the data bytes of a read transaction have no effect. No strobe is issued and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_3wire | input | 1 | 1 selects the shared single-line mode, 0 selects the separate-line mode |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_csn | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in (4-wire mode) |
| spi_miso | output | 1 | Serial data out (4-wire mode) |
| spi_miso_oe | output | 1 | Drive enable for spi_miso |
| spi_sdat_i | input | 1 | Shared line, input side (3-wire mode) |
| spi_sdat_o | output | 1 | Shared line, output side (3-wire mode) |
| spi_sdat_oe | output | 1 | Drive enable for the shared line |
| wr_stb | output | 1 | One-cycle pulse per completed write byte |
| wr_addr | output | 6 | Register address of the strobed write |
| wr_data | output | 8 | Byte of the strobed write |

## Verification
A write to register 63 with increment set completes in the same clock in which the address wraps to 0. One registered update has to commit the old address to the strobe and the register file while it loads the new address. The bench provokes this with a write burst that starts at 62 and a read burst over the same span. It judges the result by strobe addresses 62, 63, 0 in order, and by the three bytes read back in that order. A second collision is the last rising edge of a byte arriving together with the load of read data for the next byte. It is judged by reads returning the correct register on the first bit of every byte.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(DATA_W);

  typedef struct packed {
    logic              wr;
    logic              inc;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spireg_regfile.sv
module spireg_regfile
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

  // R3: a strobed byte is present in the register one clock later
  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/spireg_ctrl.sv
module spireg_ctrl
  import spireg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              din_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              tx_bit,
  output logic              rd_phase
);
  logic              sck_d, sck_d_n;
  logic [CNT_W-1:0]  bit_cnt, bit_cnt_n;
  logic              data_ph, data_ph_n;
  cmd_t              cmd, cmd_n;
  logic [DATA_W-2:0] rx_sh, rx_sh_n;
  logic [DATA_W-1:0] tx_sh, tx_sh_n;
  logic              wr_en_n;
  logic [ADDR_W-1:0] wr_addr_n;
  logic [DATA_W-1:0] wr_data_n;

  logic              rise, fall, byte_done, data_done;
  logic [DATA_W-1:0] rx_byte;
  logic [ADDR_W-1:0] load_addr;

  assign rise      = sck_s & ~sck_d;
  assign fall      = ~sck_s & sck_d;
  assign rx_byte   = {rx_sh, din_s};
  assign byte_done = ~csn_s & rise & (bit_cnt == CNT_W'(DATA_W-1));
  assign data_done = byte_done & data_ph;
  assign load_addr = !data_ph ? rx_byte[ADDR_W-1:0]
                   : (cmd.inc ? cmd.addr + ADDR_W'(1) : cmd.addr);
  assign rd_addr   = load_addr;

  always_comb begin
    sck_d_n   = sck_s;
    bit_cnt_n = bit_cnt;
    data_ph_n = data_ph;
    cmd_n     = cmd;
    rx_sh_n   = rx_sh;
    tx_sh_n   = tx_sh;
    wr_en_n   = 1'b0;
    wr_addr_n = wr_addr;
    wr_data_n = wr_data;
    if (csn_s) begin
      bit_cnt_n = '0;
      data_ph_n = 1'b0;
      tx_sh_n   = '0;
    end else if (rise) begin
      rx_sh_n   = rx_byte[DATA_W-2:0];
      bit_cnt_n = bit_cnt + CNT_W'(1);
      if (byte_done) begin
        tx_sh_n = rd_data;
        if (!data_ph) begin
          cmd_n     = cmd_t'(rx_byte);
          data_ph_n = 1'b1;
        end else begin
          if (cmd.wr) begin
            wr_en_n   = 1'b1;
            wr_addr_n = cmd.addr;
            wr_data_n = rx_byte;
          end
          cmd_n.addr = load_addr;
        end
      end
    end else if (fall && bit_cnt != '0) begin
      tx_sh_n = {tx_sh[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      bit_cnt <= '0;
      data_ph <= 1'b0;
      cmd     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sck_d   <= sck_d_n;
      bit_cnt <= bit_cnt_n;
      data_ph <= data_ph_n;
      cmd     <= cmd_n;
      rx_sh   <= rx_sh_n;
      tx_sh   <= tx_sh_n;
      wr_en   <= wr_en_n;
      wr_addr <= wr_addr_n;
      wr_data <= wr_data_n;
    end
  end

  assign tx_bit   = tx_sh[DATA_W-1];
  assign rd_phase = data_ph & ~cmd.wr;

  // R3: a strobe never lasts longer than one clock
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R4: increment steps the address by one, wrapping at the top
  p_inc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && cmd.inc) |=> cmd.addr == $past(cmd.addr) + ADDR_W'(1));
  // R5: without increment the address holds across data bytes
  p_hold_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && !cmd.inc) |=> $stable(cmd.addr));
  // R7: deselect returns the framing to a fresh command byte
  p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (bit_cnt == '0 && !data_ph));
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
  import spireg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_3wire,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              spi_sdat_i,
  output logic              spi_sdat_o,
  output logic              spi_sdat_oe,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [1:0]        rst_q;
  logic              rst_i;
  logic              din_raw, sck_s, csn_s, din_s;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] rd_addr;
  logic              tx_bit, rd_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  assign din_raw = cfg_3wire ? spi_sdat_i : spi_mosi;

  spireg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     ({spi_sck, spi_csn, din_raw}),
    .q     ({sck_s, csn_s, din_s})
  );

  spireg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i),
    .sck_s    (sck_s),
    .csn_s    (csn_s),
    .din_s    (din_s),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tx_bit   (tx_bit),
    .rd_phase (rd_phase)
  );

  spireg_regfile u_regs (
    .clk     (clk),
    .rst_n   (rst_i),
    .wr_en   (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign spi_miso    = tx_bit;
  assign spi_sdat_o  = tx_bit;
  assign spi_miso_oe = ~cfg_3wire & ~spi_csn;
  assign spi_sdat_oe = cfg_3wire & ~spi_csn & rd_phase;

  // R9: the two output lines are never driven together
  p_oe_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0({spi_miso_oe, spi_sdat_oe}));
endmodule

// File: tb/spireg_slave_bench.sv
module spireg_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rst_n, cfg_3wire, sck, csn, mosi, sdat_i;
  logic miso, miso_oe, sdat_o, sdat_oe, wr_stb;
  logic [5:0] wr_addr;
  logic [7:0] wr_data;

  int total = 0;
  int bad   = 0;
  int log_n = 0;
  logic [5:0] log_a [512];
  logic [7:0] log_d [512];
  logic [7:0] model [64];
  logic [7:0] rx_byte;
  logic       oe_and, oe_or, moe_or;

  always #(CLK_PERIOD/2) clk = ~clk;

  spireg_slave u_spireg_slave (
    .clk(clk), .rst_n(rst_n), .cfg_3wire(cfg_3wire),
    .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe),
    .spi_sdat_i(sdat_i), .spi_sdat_o(sdat_o), .spi_sdat_oe(sdat_oe),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    if (wr_stb) begin
      log_a[log_n] <= wr_addr;
      log_d[log_n] <= wr_data;
      log_n <= log_n + 1;
    end
  end

  localparam logic [13:0] VEC [6] = '{
    {6'd0, 8'hA5}, {6'd1, 8'h3C}, {6'd17, 8'hFF},
    {6'd32, 8'h01}, {6'd45, 8'h80}, {6'd63, 8'h5E}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n);
    logic [7:0] r = '0;
    logic oe;
    oe_and = 1'b1; oe_or = 1'b0; moe_or = 1'b0;
    for (int i = 7; i > 7 - n; i--) begin
      if (cfg_3wire) sdat_i = tx[i]; else mosi = tx[i];
      repeat (HALF) @(negedge clk);
      r[i]   = cfg_3wire ? sdat_o : miso;
      oe     = cfg_3wire ? sdat_oe : miso_oe;
      oe_and = oe_and & oe;
      oe_or  = oe_or | oe;
      moe_or = moe_or | miso_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    rx_byte = r;
  endtask

  task automatic xbyte(input logic [7:0] tx);
    xbits(tx, 8);
  endtask

  task automatic sel();
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic wr1(input logic [5:0] a, input logic [7:0] d);
    sel(); xbyte({2'b10, a}); xbyte(d); desel();
    model[a] = d;
  endtask

  task automatic rd1(input logic [5:0] a);
    sel(); xbyte({2'b00, a}); xbyte(8'h00); desel();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    rst_n = 1'b0; cfg_3wire = 1'b0; sck = 1'b0; csn = 1'b1; mosi = 1'b0; sdat_i = 1'b0;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1: idle state after reset
    chk("R1 miso_oe idle", miso_oe, 0);
    chk("R1 sdat_oe idle", sdat_oe, 0);
    chk("R1 no strobe", wr_stb, 0);
    rd1(6'd21);
    chk("R1 register reset value", rx_byte, 8'h00);
    chk("R1 strobe count", log_n, 0);

    // R2 R3 R6 R8: table of single writes, then read back
    for (int v = 0; v < 6; v++) begin
      n0 = log_n;
      wr1(VEC[v][13:8], VEC[v][7:0]);
      chk("R3 one strobe per byte", log_n - n0, 1);
      chk("R3 strobe addr", log_a[n0], VEC[v][13:8]);
      chk("R3 strobe data", log_d[n0], VEC[v][7:0]);
    end
    for (int v = 0; v < 6; v++) begin
      sel(); xbyte({2'b00, VEC[v][13:8]});
      xbyte(8'h00);
      chk("R8 miso_oe while selected", oe_and, 1);
      desel();
      chk("R6 R2 read data MSB first", rx_byte, VEC[v][7:0]);
      chk("R8 miso_oe after deselect", miso_oe, 0);
    end

    // R4: increment burst across the wrap
    n0 = log_n;
    sel(); xbyte(8'hC0 | 8'd62); xbyte(8'h11); xbyte(8'h22); xbyte(8'h33); desel();
    model[62] = 8'h11; model[63] = 8'h22; model[0] = 8'h33;
    chk("R4 strobe count", log_n - n0, 3);
    chk("R4 addr 62", log_a[n0], 62);
    chk("R4 addr 63", log_a[n0+1], 63);
    chk("R4 wrap to 0", log_a[n0+2], 0);
    sel(); xbyte(8'h40 | 8'd62);
    xbyte(8'h00); chk("R4 read 62", rx_byte, 8'h11);
    xbyte(8'h00); chk("R4 read 63", rx_byte, 8'h22);
    xbyte(8'h00); chk("R4 read wrapped 0", rx_byte, 8'h33);
    xbyte(8'h00); chk("R4 read 1", rx_byte, model[1]);
    desel();

    // R5: no-increment bursts
    n0 = log_n;
    sel(); xbyte(8'h80 | 8'd9); xbyte(8'h01); xbyte(8'h02); xbyte(8'h03); desel();
    model[9] = 8'h03;
    chk("R5 strobe count", log_n - n0, 3);
    chk("R5 same addr b0", log_a[n0], 9);
    chk("R5 same addr b2", log_a[n0+2], 9);
    chk("R5 neighbour untouched", model[10], 8'h00);
    sel(); xbyte(8'h00 | 8'd9);
    xbyte(8'h00); chk("R5 read 9 first", rx_byte, 8'h03);
    xbyte(8'h00); chk("R5 read 9 again", rx_byte, 8'h03);
    desel();
    rd1(6'd10);
    chk("R5 reg 10 untouched", rx_byte, 8'h00);

    // R10: input during read data has no effect
    n0 = log_n;
    sel(); xbyte(8'h00 | 8'd9); xbyte(8'hFF); xbyte(8'hAA); desel();
    chk("R10 no strobe on read", log_n - n0, 0);
    rd1(6'd9);
    chk("R10 reg unchanged", rx_byte, 8'h03);

    // R7: abort inside command byte and inside a data byte
    n0 = log_n;
    sel(); xbits(8'h80 | 8'd20, 5); desel();
    sel(); xbyte(8'h80 | 8'd21); xbyte(8'h5A); desel();
    chk("R7 one strobe after abort", log_n - n0, 1);
    chk("R7 fresh command addr", log_a[n0], 21);
    chk("R7 fresh command data", log_d[n0], 8'h5A);
    n0 = log_n;
    sel(); xbyte(8'h80 | 8'd22); xbyte(8'h77); xbits(8'h66, 3); desel();
    chk("R7 partial data byte dropped", log_n - n0, 1);
    rd1(6'd22);
    chk("R7 reg holds full byte", rx_byte, 8'h77);

    // R9: shared-line mode
    cfg_3wire = 1'b1;
    repeat (HALF) @(negedge clk);
    n0 = log_n;
    sel(); xbyte(8'h80 | 8'd30);
    chk("R9 no drive in command", oe_or, 0);
    xbyte(8'hC3);
    chk("R9 no drive during write data", oe_or, 0);
    desel();
    chk("R9 write via sdat_i", log_d[n0], 8'hC3);
    sel(); xbyte(8'h00 | 8'd30);
    chk("R9 no drive in read command", oe_or, 0);
    xbyte(8'h00);
    chk("R9 drive during read data", oe_and, 1);
    chk("R9 miso_oe held low", moe_or, 0);
    chk("R9 read via sdat_o", rx_byte, 8'hC3);
    desel();
    chk("R9 released after deselect", sdat_oe, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule